// File: doc/BRIEF.md
# Load-Port Parallel Handoff Controller

This block is the equipment-side controller for the parallel-wire handshake between an overhead carrier-transport robot and one load port. It registers the robot-driven lines, which are two carrier-select bits, VALID, TR_REQ, BUSY and COMPT. It also registers the emergency-stop line and three equipment-side inputs: carrier present, accept and clear. From these it walks a nine-state handoff sequence. The sequence is the same for an inbound load and an outbound unload, except for the request line the controller raises.

Three supervision timers watch the three phases in which one side waits on the other. If a phase lasts too long, the controller parks in a fault state and records which phase stalled. An emergency stop overrides everything. Both parking states are left only through an explicit clear while the lines are quiet. The timer limits are cycle counts supplied on input ports, so each port instance can be tuned.

Top module: `lpio_handoff_ctrl`

## Requirements
- R1: After reset the state is Idle (code 0), the fault reason is 0, and L_REQ, U_REQ, READY and the step pulse are low.
- R2: State codes are Idle=0, CarrierPresent=1, ValidAsserted=2, LoadReady=3, UnloadReady=4, Transferring=5, Complete=6, EmergencyStop=7, HandoffFault=8. The load path is as follows. Idle moves to 1 when this port is selected. State 1 moves to 2 on VALID. State 2 moves to 3 when accept is high and carrier present is low. State 3 moves to 5 once TR_REQ and BUSY are both high. State 5 moves to 6 when BUSY is low and COMPT is high. State 6 returns to 0 when VALID, TR_REQ, BUSY and COMPT are low and the port is no longer selected.
- R3: With carrier present high at acceptance, state 2 moves to UnloadReady (4) instead of state 3. State 4 moves on to 5 under the same rule as state 3.
- R4: L_REQ is high only in state 3, U_REQ only in state 4, and READY in states 3, 4 and 5.
- R5: Robot-driven transitions (those out of states 0, 1, 3, 4, 5 and 6) are taken only in a cycle whose registered robot lines differ from the previous registered value. Levels that are already high cause no move until some robot line changes.
- R6: The port is selected only when the select code {CS_1,CS_0} equals port_id_i and is nonzero; code 00 means no port is selected.
- R7: Staying in state 2 for tmo_ack_i cycles moves the state to 8 with fault reason 1.
- R8: Staying in state 3 or 4 for tmo_start_i cycles moves the state to 8 with fault reason 2.
- R9: Staying in state 5 for tmo_move_i cycles moves the state to 8 with fault reason 3.
- R10: Leaving a timed state within limit−1 cycles cancels its timer, and no fault is recorded.
- R11: A registered emergency stop moves any state to 7 on the next edge, keeping the fault reason.
- R12: States 7 and 8 return to 0 with fault reason 0 only when clear is high, emergency stop is low and all six robot lines are low. Otherwise clear is ignored.
- R13: step_o is high for exactly the one cycle in which state_o shows a new value.
- R14: lines_o is the 10-bit line image with CS_0=bit0, CS_1=bit1, VALID=bit2, TR_REQ=bit3, BUSY=bit4, COMPT=bit5, L_REQ=bit6, U_REQ=bit7, READY=bit8, ES=bit9. The robot lines and ES are shown as registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_id_i | input | 2 | Select code of this port (nonzero) |
| cs_i | input | 2 | Carrier-select bits from the robot, bit0 = CS_0 |
| valid_i | input | 1 | Robot VALID |
| tr_req_i | input | 1 | Robot transfer request |
| busy_i | input | 1 | Robot transfer in progress |
| compt_i | input | 1 | Robot transfer complete |
| estop_i | input | 1 | Shared emergency-stop line |
| carrier_here_i | input | 1 | Port holds a carrier (unload) when high |
| accept_i | input | 1 | Equipment agrees to the handoff |
| clear_i | input | 1 | Leave fault or emergency stop |
| tmo_ack_i | input | TW | Limit in cycles for the VALID answer phase |
| tmo_start_i | input | TW | Limit in cycles for the wait on robot motion |
| tmo_move_i | input | TW | Limit in cycles for the transfer itself |
| load_req_o | output | 1 | L_REQ to robot |
| unload_req_o | output | 1 | U_REQ to robot |
| ready_o | output | 1 | READY to robot |
| state_o | output | 4 | Current handoff state code |
| fault_o | output | 2 | Fault reason, 0 none, 1..3 by phase |
| step_o | output | 1 | One-cycle pulse on a state change |
| lines_o | output | 10 | Registered ten-line image |

## Verification
Every input goes through one register before the state logic sees it. A change driven before clock edge N therefore shows in state_o, fault_o, step_o and the request outputs after edge N+1, and in lines_o after edge N alone. A timed state stays visible for exactly its limit in cycles before HandoffFault appears. The bench model steps on the same edges with its own sampled copies of the inputs and an age counter. It compares all outputs at each falling edge, half a period after the outputs settle. The directed checks wait three falling edges after a stimulus. Timer boundaries are checked by counting the falling edges that show the timed state.

// File: rtl/lpio_pkg.sv
package lpio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_SELECTED   = 4'd1,
        ST_VALID      = 4'd2,
        ST_LOAD_RDY   = 4'd3,
        ST_UNLOAD_RDY = 4'd4,
        ST_MOVING     = 4'd5,
        ST_DONE       = 4'd6,
        ST_ESTOP      = 4'd7,
        ST_FAULT      = 4'd8
    } hs_state_e;

    typedef enum logic [1:0] {
        FR_NONE      = 2'd0,
        FR_NO_ANSWER = 2'd1,
        FR_NO_START  = 2'd2,
        FR_STALLED   = 2'd3
    } fault_e;

    // robot-driven lines, MSB first
    typedef struct packed {
        logic [1:0] sel;
        logic       valid;
        logic       tr_req;
        logic       busy;
        logic       compt;
    } robot_lines_t;

    // equipment-side inputs
    typedef struct packed {
        logic estop;
        logic carrier_here;
        logic accept;
        logic clear;
    } equip_in_t;

    typedef struct packed {
        hs_state_e state;
        fault_e    fault;
        logic      step;
    } ctl_regs_t;

    localparam int NUM_PHASES = 3;

endpackage

// File: rtl/lpio_line_sampler.sv
module lpio_line_sampler
    import lpio_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  robot_lines_t rob_i,
    input  equip_in_t    eq_i,
    output robot_lines_t rob_q,
    output equip_in_t    eq_q,
    output logic         event_q
);

    robot_lines_t rob_d;
    equip_in_t    eq_d;
    logic         event_d;

    always_comb begin
        rob_d   = rob_i;
        eq_d    = eq_i;
        event_d = (rob_i != rob_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rob_q   <= '0;
            eq_q    <= '0;
            event_q <= 1'b0;
        end else begin
            rob_q   <= rob_d;
            eq_q    <= eq_d;
            event_q <= event_d;
        end
    end

endmodule

// File: rtl/lpio_phase_timer.sv
module lpio_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW:0]   next_age;

    always_comb begin
        if (!active)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        next_age = {1'b0, cnt_q} + 1'b1;
        expired  = active && (next_age >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lpio_handoff_ctrl.sv
module lpio_handoff_ctrl
    import lpio_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    port_id_i,
    input  logic [1:0]    cs_i,
    input  logic          valid_i,
    input  logic          tr_req_i,
    input  logic          busy_i,
    input  logic          compt_i,
    input  logic          estop_i,
    input  logic          carrier_here_i,
    input  logic          accept_i,
    input  logic          clear_i,
    input  logic [TW-1:0] tmo_ack_i,
    input  logic [TW-1:0] tmo_start_i,
    input  logic [TW-1:0] tmo_move_i,
    output logic          load_req_o,
    output logic          unload_req_o,
    output logic          ready_o,
    output logic [3:0]    state_o,
    output logic [1:0]    fault_o,
    output logic          step_o,
    output logic [9:0]    lines_o
);

    robot_lines_t rob_raw, rob_q;
    equip_in_t    eq_raw, eq_q;
    logic         rob_event;

    assign rob_raw = '{sel: cs_i, valid: valid_i, tr_req: tr_req_i,
                       busy: busy_i, compt: compt_i};
    assign eq_raw  = '{estop: estop_i, carrier_here: carrier_here_i,
                       accept: accept_i, clear: clear_i};

    lpio_line_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .rob_i   (rob_raw),
        .eq_i    (eq_raw),
        .rob_q   (rob_q),
        .eq_q    (eq_q),
        .event_q (rob_event)
    );

    ctl_regs_t cur_q, nxt_d;

    // phase supervision: 0 = answer to VALID, 1 = robot start, 2 = transfer
    logic [TW-1:0]         phase_lim [NUM_PHASES];
    logic [NUM_PHASES-1:0] phase_on;
    logic [NUM_PHASES-1:0] phase_exp;

    always_comb begin
        phase_lim[0] = tmo_ack_i;
        phase_lim[1] = tmo_start_i;
        phase_lim[2] = tmo_move_i;
        phase_on[0]  = (cur_q.state == ST_VALID);
        phase_on[1]  = (cur_q.state == ST_LOAD_RDY) || (cur_q.state == ST_UNLOAD_RDY);
        phase_on[2]  = (cur_q.state == ST_MOVING);
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        lpio_phase_timer #(.TW(TW)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (phase_on[g]),
            .limit   (phase_lim[g]),
            .expired (phase_exp[g])
        );
    end

    logic addressed;
    logic lines_quiet;
    logic motion_quiet;

    always_comb begin
        addressed    = (rob_q.sel == port_id_i) && (rob_q.sel != 2'b00);
        lines_quiet  = (rob_q == '0);
        motion_quiet = !rob_q.valid && !rob_q.tr_req && !rob_q.busy && !rob_q.compt;

        nxt_d       = cur_q;
        nxt_d.step  = 1'b0;

        if (eq_q.estop) begin
            nxt_d.state = ST_ESTOP;
        end else begin
            unique case (cur_q.state)
                ST_ESTOP, ST_FAULT: begin
                    if (eq_q.clear && lines_quiet) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.fault = FR_NONE;
                    end
                end
                ST_IDLE: begin
                    if (rob_event && addressed) nxt_d.state = ST_SELECTED;
                end
                ST_SELECTED: begin
                    if (rob_event) begin
                        if (!addressed)       nxt_d.state = ST_IDLE;
                        else if (rob_q.valid) nxt_d.state = ST_VALID;
                    end
                end
                ST_VALID: begin
                    if (eq_q.accept) begin
                        nxt_d.state = eq_q.carrier_here ? ST_UNLOAD_RDY : ST_LOAD_RDY;
                    end else if (phase_exp[0]) begin
                        nxt_d.state = ST_FAULT;
                        nxt_d.fault = FR_NO_ANSWER;
                    end
                end
                ST_LOAD_RDY, ST_UNLOAD_RDY: begin
                    if (rob_event && rob_q.tr_req && rob_q.busy) begin
                        nxt_d.state = ST_MOVING;
                    end else if (phase_exp[1]) begin
                        nxt_d.state = ST_FAULT;
                        nxt_d.fault = FR_NO_START;
                    end
                end
                ST_MOVING: begin
                    if (rob_event && !rob_q.busy && rob_q.compt) begin
                        nxt_d.state = ST_DONE;
                    end else if (phase_exp[2]) begin
                        nxt_d.state = ST_FAULT;
                        nxt_d.fault = FR_STALLED;
                    end
                end
                ST_DONE: begin
                    if (rob_event && !addressed && motion_quiet) nxt_d.state = ST_IDLE;
                end
                default: begin
                    nxt_d.state = ST_FAULT;
                end
            endcase
        end

        nxt_d.step = (nxt_d.state != cur_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, fault: FR_NONE, step: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        load_req_o   = (cur_q.state == ST_LOAD_RDY);
        unload_req_o = (cur_q.state == ST_UNLOAD_RDY);
        ready_o      = (cur_q.state == ST_LOAD_RDY) || (cur_q.state == ST_UNLOAD_RDY)
                    || (cur_q.state == ST_MOVING);
        state_o      = cur_q.state;
        fault_o      = cur_q.fault;
        step_o       = cur_q.step;
        lines_o      = {eq_q.estop, ready_o, unload_req_o, load_req_o,
                        rob_q.compt, rob_q.busy, rob_q.tr_req, rob_q.valid,
                        rob_q.sel[1], rob_q.sel[0]};
    end

endmodule

// File: rtl/lpio_handoff_chk.sv
module lpio_handoff_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_req_o,
    input logic       unload_req_o,
    input logic       ready_o,
    input logic [3:0] state_o,
    input logic [1:0] fault_o,
    input logic       step_o,
    input logic [9:0] lines_o
);

    // R2: only the nine defined codes appear
    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 4'd8);

    // R4: requests never together
    p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_req_o && unload_req_o));

    // R4: READY only in the ready and moving states
    p_ready_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (state_o == 4'd3 || state_o == 4'd4 || state_o == 4'd5));

    // R7: fault state always carries a reason
    p_fault_has_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd8) |-> (fault_o != 2'd0));

    // R12: idle never keeps an old reason
    p_idle_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0) |-> (fault_o == 2'd0));

    // R11: stop state entered only after the registered stop line was high
    p_estop_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o == 4'd7) |-> $past(lines_o[9]));

    // R13: a new state shows with the pulse
    p_step_on_change_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> step_o);

    // R13: the pulse never without a change
    p_step_only_change_r13: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (state_o != $past(state_o)));

endmodule

bind lpio_handoff_ctrl lpio_handoff_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_req_o   (load_req_o),
    .unload_req_o (unload_req_o),
    .ready_o      (ready_o),
    .state_o      (state_o),
    .fault_o      (fault_o),
    .step_o       (step_o),
    .lines_o      (lines_o)
);

// File: tb/lpio_handoff_ctrl_test.sv
module lpio_handoff_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam logic [1:0] PORT = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cs = '0;
    logic valid = 0, tr = 0, busy = 0, compt = 0;
    logic estop = 0, here = 0, accept = 0, clear = 0;
    logic [TW-1:0] lim1 = 16'd100, lim2 = 16'd100, lim3 = 16'd100;
    logic lreq, ureq, ready, step;
    logic [3:0] state;
    logic [1:0] fault;
    logic [9:0] lines;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpio_handoff_ctrl #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .port_id_i(PORT), .cs_i(cs),
        .valid_i(valid), .tr_req_i(tr), .busy_i(busy), .compt_i(compt),
        .estop_i(estop), .carrier_here_i(here), .accept_i(accept), .clear_i(clear),
        .tmo_ack_i(lim1), .tmo_start_i(lim2), .tmo_move_i(lim3),
        .load_req_o(lreq), .unload_req_o(ureq), .ready_o(ready),
        .state_o(state), .fault_o(fault), .step_o(step), .lines_o(lines)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int ms, mf, age;
    bit mstep, se, shere, sacc, sclr, sev;
    bit [5:0] sr;

    always @(posedge clk or negedge rst_n) begin
        int ns, nf;
        bit addr, quiet;
        bit [5:0] now;
        if (!rst_n) begin
            ms = 0; mf = 0; age = 0; mstep = 0;
            sr = 0; se = 0; shere = 0; sacc = 0; sclr = 0; sev = 0;
        end else begin
            addr  = (sr[5:4] == PORT) && (sr[5:4] != 0);
            quiet = (sr == 0);
            ns = ms; nf = mf;
            if (se) ns = 7;
            else case (ms)
                7, 8: if (sclr && quiet) begin ns = 0; nf = 0; end
                0: if (sev && addr) ns = 1;
                1: if (sev) begin
                       if (!addr) ns = 0;
                       else if (sr[3]) ns = 2;
                   end
                2: if (sacc) ns = shere ? 4 : 3;
                   else if (age + 1 >= int'(lim1)) begin ns = 8; nf = 1; end
                3, 4: if (sev && sr[2] && sr[1]) ns = 5;
                   else if (age + 1 >= int'(lim2)) begin ns = 8; nf = 2; end
                5: if (sev && !sr[1] && sr[0]) ns = 6;
                   else if (age + 1 >= int'(lim3)) begin ns = 8; nf = 3; end
                6: if (sev && !addr && sr[3:0] == 0) ns = 0;
                default: ;
            endcase
            mstep = (ns != ms);
            age   = (ns != ms) ? 0 : age + 1;
            ms = ns; mf = nf;
            now   = {cs, valid, tr, busy, compt};
            sev   = (now != sr);
            sr    = now;
            se = estop; shere = here; sacc = accept; sclr = clear;
        end
    end

    always @(negedge clk) begin
        bit er, el, eu;
        if (rst_n && !done) begin
            el = (ms == 3); eu = (ms == 4); er = (ms >= 3 && ms <= 5);
            check("R2 state", int'(state), ms);
            check("R7 fault", int'(fault), mf);
            check("R13 step", int'(step), int'(mstep));
            check("R4 lreq", int'(lreq), int'(el));
            check("R4 ureq", int'(ureq), int'(eu));
            check("R4 ready", int'(ready), int'(er));
            check("R14 lines", int'(lines),
                  int'({se, er, eu, el, sr[0], sr[1], sr[2], sr[3], sr[5], sr[4]}));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(input logic [1:0] s, input logic v, input logic t,
                       input logic b, input logic c);
        @(negedge clk);
        cs = s; valid = v; tr = t; busy = b; compt = c;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic recover();
        @(negedge clk);
        cs = 0; valid = 0; tr = 0; busy = 0; compt = 0; accept = 0; estop = 0; clear = 1;
        @(negedge clk);
        clear = 0;
        settle(3);
    endtask

    task automatic to_moving(input logic carrier);
        here = carrier;
        put(PORT, 0, 0, 0, 0); settle(3);
        put(PORT, 1, 0, 0, 0); settle(3);
        @(negedge clk); accept = 1; settle(3);
        @(negedge clk); accept = 0;
        put(PORT, 1, 1, 1, 0); settle(3);
    endtask

    initial begin
        int cnt;
        settle(3);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 reset state", int'(state), 0);
        check("R1 reset fault", int'(fault), 0);
        check("R1 reset outputs", int'({lreq, ureq, ready, step}), 0);

        // R2 + R13 inbound load
        put(PORT, 0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        check("R13 pulse with new state", int'({step, state}), int'({1'b1, 4'd1}));
        @(negedge clk);
        check("R13 pulse one cycle", int'(step), 0);
        put(PORT, 1, 0, 0, 0); settle(3);
        check("R2 valid asserted", int'(state), 2);
        @(negedge clk); accept = 1; settle(3);
        check("R2 load ready", int'(state), 3);
        check("R4 L_REQ and READY", int'({lreq, ureq, ready}), 3'b101);
        @(negedge clk); accept = 0;
        put(PORT, 1, 1, 0, 0); settle(3);
        check("R2 TR_REQ alone no move", int'(state), 3);
        put(PORT, 1, 1, 1, 0); settle(3);
        check("R2 transferring", int'(state), 5);
        put(PORT, 1, 1, 0, 1); settle(3);
        check("R2 complete", int'(state), 6);
        put(0, 0, 0, 0, 0); settle(3);
        check("R2 back to idle", int'(state), 0);

        // R3 outbound unload
        to_moving(1'b1);
        check("R3 unload reaches transferring", int'(state), 5);
        put(PORT, 1, 1, 0, 1); settle(3);
        put(0, 0, 0, 0, 0); settle(3);
        check("R3 unload ends idle", int'(state), 0);
        here = 1;
        put(PORT, 0, 0, 0, 0); settle(3);
        put(PORT, 1, 0, 0, 0); settle(3);
        @(negedge clk); accept = 1; settle(3);
        check("R3 unload ready state", int'(state), 4);
        check("R4 U_REQ and READY", int'({lreq, ureq, ready}), 3'b011);
        @(negedge clk); accept = 0; here = 0;
        put(0, 0, 0, 0, 0); settle(2);
        recover_hold: begin end
        put(PORT, 1, 1, 1, 0); settle(3);
        put(PORT, 1, 0, 0, 1); settle(3);
        put(0, 0, 0, 0, 0); settle(3);
        check("R3 second unload idle", int'(state), 0);

        // R5 levels already high do not move the state
        put(PORT, 0, 0, 0, 0); settle(3);
        put(PORT, 1, 0, 0, 0); settle(3);
        put(PORT, 1, 1, 1, 0); settle(3);
        @(negedge clk); accept = 1; settle(5);
        check("R5 no robot change no move", int'(state), 3);
        @(negedge clk); accept = 0;
        put(PORT, 1, 1, 1, 1); settle(3);
        check("R5 change then move", int'(state), 5);
        put(PORT, 1, 1, 0, 1); settle(3);
        put(0, 0, 0, 0, 0); settle(3);
        check("R5 idle again", int'(state), 0);

        // R6 port match
        put(2'd1, 0, 0, 0, 0); settle(3);
        check("R6 other port ignored", int'(state), 0);
        put(2'd3, 1, 0, 0, 0); settle(3);
        check("R6 code 3 ignored", int'(state), 0);
        // R14 line image while idle: sel=01, valid, busy
        put(2'd1, 1, 0, 1, 0); settle(3);
        check("R14 line bit order", int'(lines), 10'h015);
        put(0, 0, 0, 0, 0); settle(3);

        // R7 answer timeout, counted in cycles
        lim1 = 16'd4;
        put(PORT, 0, 0, 0, 0); settle(3);
        put(PORT, 1, 0, 0, 0);
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (state == 4'd2) cnt++;
        end
        check("R7 cycles in answer phase", cnt, 4);
        check("R7 fault state", int'(state), 8);
        check("R7 fault reason", int'(fault), 1);
        // R12 clear ignored while a robot line is high
        @(negedge clk); clear = 1; @(negedge clk); clear = 0; settle(3);
        check("R12 clear ignored lines high", int'({state, fault}), int'({4'd8, 2'd1}));
        recover();
        check("R12 clear to idle", int'({state, fault}), 0);

        // R10 cancel one cycle before expiry
        put(PORT, 0, 0, 0, 0); settle(3);
        put(PORT, 1, 0, 0, 0);
        settle(3);
        accept = 1;
        settle(3);
        check("R10 cancel before limit", int'({state, fault}), int'({4'd3, 2'd0}));
        @(negedge clk); accept = 0;
        put(0, 0, 0, 0, 0);
        lim1 = 16'd100;

        // R8 start timeout
        lim2 = 16'd5;
        settle(12);
        check("R8 fault state", int'(state), 8);
        check("R8 fault reason", int'(fault), 2);
        recover();
        lim2 = 16'd100;

        // R9 transfer timeout
        lim3 = 16'd6;
        to_moving(1'b0);
        settle(6);
        check("R9 fault reason", int'({state, fault}), int'({4'd8, 2'd3}));
        recover();
        lim3 = 16'd100;

        // R11 emergency stop from transferring
        to_moving(1'b0);
        @(negedge clk); estop = 1; settle(3);
        check("R11 stop state", int'(state), 7);
        check("R11 outputs low", int'({lreq, ureq, ready}), 0);
        put(0, 0, 0, 0, 0);
        @(negedge clk); clear = 1; @(negedge clk); clear = 0; settle(3);
        check("R12 clear ignored during stop", int'(state), 7);
        recover();
        check("R12 stop cleared", int'({state, fault}), 0);
        // R11 from idle
        @(negedge clk); estop = 1; settle(3);
        check("R11 stop from idle", int'(state), 7);
        recover();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule